// File: doc/BRIEF.md
# Privileged Stack Pointer Fetch Unit

On an inward privilege change the processor needs the stack selector and stack pointer that belong to the target level. Those values sit in the current task state segment. This unit takes the target level (0, 1 or 2) and the task register state: the selector, the base, the scaled limit, the segment kind and a cache-valid flag. From these it works out where the level's stack slot lies, checks that slot against the segment limit, and reads it through a simple memory read port. The stack pointer is read first and the stack selector second.

Two segment layouts are handled, and each has its own slot spacing, bounds rule and data width. When the 16-bit layout supplies a stack pointer, the unit zero-extends it to 32 bits. Every accepted request ends with exactly one one-cycle pulse:
- completion, with the selector and pointer presented on the outputs;
- a stack-segment fault, with an error code built from the task register selector;
- a bad-state indication, when the task register contents cannot be used at all.

The unit does not load or check the descriptor for the returned selector.

Top module: `priv_stack_fetch`

## Requirements
- R1: After reset, mem_req_o, done_o, fault_o and bad_state_o are all 0.
- R2: For kind 9 (32-bit layout) the slot offset is 8*level+4. The pointer is read as a 4-byte access (mem_wide_o=1) at base+offset. The selector is read as a 2-byte access (mem_wide_o=0) at base+offset+4. sp_o is the full 32-bit read data.
- R3: For kind 1 (16-bit layout) the slot offset is 4*level+2. The pointer is read as a 2-byte access at base+offset and the selector at base+offset+2. sp_o holds read data bits 15:0 with bits 31:16 forced to zero.
- R4: For kind 9, a fault is raised instead of any memory access when offset+7 is greater than the limit. offset+7 equal to the limit is accepted.
- R5: For kind 1, a fault is raised instead of any memory access when offset+4 is greater than the limit. offset+4 equal to the limit is accepted.
- R6: On a fault, fault_o pulses for one cycle. err_code_o then equals the task register selector with bits 1:0 cleared.
- R7: bad_state_o pulses for one cycle, with no fault and no memory access, when any of these holds: the cache-valid flag is 0, the kind is neither 1 nor 9, or the level is 3.
- R8: A memory request stays asserted with a stable address until mem_ready_i is seen. The pointer read completes before the selector read starts. done_o pulses one cycle after the selector read's ready. ss_o (read data bits 15:0) and sp_o hold their values after done_o until the next accepted start.
- R9: start_i is ignored while a fetch is in progress. No second fetch follows and the result is that of the first request.
- R10: Each accepted start produces exactly one pulse on exactly one of done_o, fault_o and bad_state_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a fetch (accepted when idle) |
| level_i | input | 2 | Target privilege level |
| tr_sel_i | input | 16 | Task register selector |
| tr_base_i | input | 32 | Task segment base address |
| tr_limit_i | input | 32 | Task segment scaled limit |
| tr_kind_i | input | 4 | Task segment kind (1 = 16-bit, 9 = 32-bit) |
| tr_ok_i | input | 1 | Task register cache valid |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_wide_o | output | 1 | 1 = 4-byte read, 0 = 2-byte read |
| mem_ready_i | input | 1 | Read data valid, request completes |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Fetch completed pulse |
| ss_o | output | 16 | Fetched stack selector |
| sp_o | output | 32 | Fetched stack pointer |
| fault_o | output | 1 | Stack-segment fault pulse |
| err_code_o | output | 16 | Fault error code |
| bad_state_o | output | 1 | Unusable task register pulse |

## Verification
Several rules are checked by assertions on every cycle:
- at most one of the three outcomes is pulsed at a time;
- a pending request keeps its address until ready;
- no access ever reaches past the latched segment limit;
- a fault's error code always has bits 1:0 clear.

The bench scenarios cover what depends on the data:
- the exact slot addresses and access widths for each level and layout;
- the acceptance of a slot that ends exactly at the limit;
- the zero extension of a 16-bit pointer;
- the fact that a start arriving during a fetch starts nothing new.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam logic [3:0] KIND_NARROW = 4'd1;
  localparam logic [3:0] KIND_WIDE   = 4'd9;
  localparam int WIDE_BASE_OFS   = 4;
  localparam int WIDE_SPAN       = 7;
  localparam int WIDE_SS_STEP    = 4;
  localparam int NARROW_BASE_OFS = 2;
  localparam int NARROW_SPAN     = 4;
  localparam int NARROW_SS_STEP  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_SP = 2'd1,
    ST_RD_SS = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/psf_locate.sv
module psf_locate
  import psf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        level_i,
  input  logic [3:0]        kind_i,
  input  logic              tr_ok_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic [ADDR_W-1:0] sp_addr_o,
  output logic [ADDR_W-1:0] ss_addr_o,
  output logic              wide_o,
  output logic              bad_o,
  output logic              over_o
);
  localparam int EXT_W = ADDR_W + 1;

  logic              narrow;
  logic [ADDR_W-1:0] slot_ofs;
  logic [ADDR_W-1:0] ss_step;
  logic [EXT_W-1:0]  slot_last;

  always_comb begin
    wide_o = (kind_i == KIND_WIDE);
    narrow = (kind_i == KIND_NARROW);
    if (wide_o) begin
      slot_ofs  = ADDR_W'({level_i, 3'b000}) + ADDR_W'(WIDE_BASE_OFS);
      ss_step   = ADDR_W'(WIDE_SS_STEP);
      slot_last = {1'b0, slot_ofs} + EXT_W'(WIDE_SPAN);
    end else begin
      slot_ofs  = ADDR_W'({level_i, 2'b00}) + ADDR_W'(NARROW_BASE_OFS);
      ss_step   = ADDR_W'(NARROW_SS_STEP);
      slot_last = {1'b0, slot_ofs} + EXT_W'(NARROW_SPAN);
    end
    over_o    = slot_last > {1'b0, limit_i};
    bad_o     = !tr_ok_i || !(wide_o || narrow) || (level_i == 2'd3);
    sp_addr_o = base_i + slot_ofs;
    ss_addr_o = base_i + slot_ofs + ss_step;
  end
endmodule

// File: rtl/psf_sequencer.sv
module psf_sequencer
  import psf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int SP_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [ADDR_W-1:0] sp_addr_i,
  input  logic [ADDR_W-1:0] ss_addr_i,
  input  logic              wide_i,
  input  logic              bad_i,
  input  logic              over_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_wide_o,
  input  logic              mem_ready_i,
  input  logic [SP_W-1:0]   mem_rdata_i,
  output logic              done_o,
  output logic [SEL_W-1:0]  ss_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              fault_o,
  output logic [SEL_W-1:0]  err_code_o,
  output logic              bad_state_o
);
  localparam int HALF_W = SP_W / 2;

  fetch_st_e         st_q, st_n;
  logic [ADDR_W-1:0] sp_addr_q, sp_addr_n;
  logic [ADDR_W-1:0] ss_addr_q, ss_addr_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [ADDR_W-1:0] limit_q, limit_n;
  logic              wide_q, wide_n;
  logic [SP_W-1:0]   sp_q, sp_n;
  logic [SEL_W-1:0]  ss_q, ss_n;
  logic [SEL_W-1:0]  err_q, err_n;
  logic              done_q, done_n;
  logic              fault_q, fault_n;
  logic              bad_q, bad_n;

  always_comb begin
    st_n      = st_q;
    sp_addr_n = sp_addr_q;
    ss_addr_n = ss_addr_q;
    base_n    = base_q;
    limit_n   = limit_q;
    wide_n    = wide_q;
    sp_n      = sp_q;
    ss_n      = ss_q;
    err_n     = err_q;
    done_n    = 1'b0;
    fault_n   = 1'b0;
    bad_n     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (bad_i) begin
            bad_n = 1'b1;
          end else if (over_i) begin
            fault_n = 1'b1;
            err_n   = {sel_i[SEL_W-1:2], 2'b00};
          end else begin
            st_n      = ST_RD_SP;
            sp_addr_n = sp_addr_i;
            ss_addr_n = ss_addr_i;
            base_n    = base_i;
            limit_n   = limit_i;
            wide_n    = wide_i;
          end
        end
      end
      ST_RD_SP: begin
        if (mem_ready_i) begin
          st_n = ST_RD_SS;
          sp_n = wide_q ? mem_rdata_i : {{(SP_W-HALF_W){1'b0}}, mem_rdata_i[HALF_W-1:0]};
        end
      end
      ST_RD_SS: begin
        if (mem_ready_i) begin
          st_n   = ST_IDLE;
          ss_n   = mem_rdata_i[SEL_W-1:0];
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sp_addr_q <= '0;
      ss_addr_q <= '0;
      base_q    <= '0;
      limit_q   <= '0;
      wide_q    <= 1'b0;
      sp_q      <= '0;
      ss_q      <= '0;
      err_q     <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      bad_q     <= 1'b0;
    end else begin
      st_q      <= st_n;
      sp_addr_q <= sp_addr_n;
      ss_addr_q <= ss_addr_n;
      base_q    <= base_n;
      limit_q   <= limit_n;
      wide_q    <= wide_n;
      sp_q      <= sp_n;
      ss_q      <= ss_n;
      err_q     <= err_n;
      done_q    <= done_n;
      fault_q   <= fault_n;
      bad_q     <= bad_n;
    end
  end

  assign mem_req_o   = (st_q != ST_IDLE);
  assign mem_addr_o  = (st_q == ST_RD_SP) ? sp_addr_q : ss_addr_q;
  assign mem_wide_o  = (st_q == ST_RD_SP) && wide_q;
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign bad_state_o = bad_q;
  assign ss_o        = ss_q;
  assign sp_o        = sp_q;
  assign err_code_o  = err_q;

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fault_o, bad_state_o}));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R4
  in_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (({1'b0, mem_addr_o - base_q} + (mem_wide_o ? (ADDR_W+1)'(3) : (ADDR_W+1)'(1)))
                   <= {1'b0, limit_q}));

  // R6
  err_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (err_code_o[1:0] == 2'b00));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o);

  // R7
  bad_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_state_o || fault_o) |-> !mem_req_o);
endmodule

// File: rtl/priv_stack_fetch.sv
module priv_stack_fetch #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int SP_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        level_i,
  input  logic [SEL_W-1:0]  tr_sel_i,
  input  logic [ADDR_W-1:0] tr_base_i,
  input  logic [ADDR_W-1:0] tr_limit_i,
  input  logic [3:0]        tr_kind_i,
  input  logic              tr_ok_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_wide_o,
  input  logic              mem_ready_i,
  input  logic [SP_W-1:0]   mem_rdata_i,
  output logic              done_o,
  output logic [SEL_W-1:0]  ss_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              fault_o,
  output logic [SEL_W-1:0]  err_code_o,
  output logic              bad_state_o
);
  logic [ADDR_W-1:0] sp_addr, ss_addr;
  logic              wide, bad, over;

  psf_locate #(.ADDR_W(ADDR_W)) u_locate (
    .level_i   (level_i),
    .kind_i    (tr_kind_i),
    .tr_ok_i   (tr_ok_i),
    .base_i    (tr_base_i),
    .limit_i   (tr_limit_i),
    .sp_addr_o (sp_addr),
    .ss_addr_o (ss_addr),
    .wide_o    (wide),
    .bad_o     (bad),
    .over_o    (over)
  );

  psf_sequencer #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .SP_W(SP_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .sel_i       (tr_sel_i),
    .base_i      (tr_base_i),
    .limit_i     (tr_limit_i),
    .sp_addr_i   (sp_addr),
    .ss_addr_i   (ss_addr),
    .wide_i      (wide),
    .bad_i       (bad),
    .over_i      (over),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wide_o  (mem_wide_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .ss_o        (ss_o),
    .sp_o        (sp_o),
    .fault_o     (fault_o),
    .err_code_o  (err_code_o),
    .bad_state_o (bad_state_o)
  );
endmodule

// File: tb/tb_priv_stack_fetch.sv
`timescale 1ns/1ps
module tb_priv_stack_fetch;
  typedef struct packed {
    logic [1:0]  lvl;
    logic [3:0]  kind;
    logic [31:0] base;
    logic [31:0] limit;
    logic        ok;
    logic [15:0] sel;
    logic [1:0]  expk;  // 0 done, 1 fault, 2 bad
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd9, 32'h0000_1000, 32'h0000_0067, 1'b1, 16'h0028, 2'd0},
    '{2'd1, 4'd9, 32'h2000_0000, 32'h0000_0067, 1'b1, 16'h0031, 2'd0},
    '{2'd2, 4'd9, 32'h0004_0000, 32'h0000_001B, 1'b1, 16'h0040, 2'd0},
    '{2'd2, 4'd9, 32'h0004_0000, 32'h0000_001A, 1'b1, 16'h002B, 2'd1},
    '{2'd0, 4'd1, 32'h0000_0500, 32'h0000_002B, 1'b1, 16'h0018, 2'd0},
    '{2'd2, 4'd1, 32'h0000_0700, 32'h0000_000E, 1'b1, 16'h0020, 2'd0},
    '{2'd2, 4'd1, 32'h0000_0700, 32'h0000_000D, 1'b1, 16'h0013, 2'd1},
    '{2'd1, 4'd3, 32'h0000_0800, 32'h0000_00FF, 1'b1, 16'h0050, 2'd2},
    '{2'd0, 4'd9, 32'h0000_0900, 32'h0000_00FF, 1'b0, 16'h0058, 2'd2},
    '{2'd3, 4'd9, 32'h0000_0A00, 32'h0000_00FF, 1'b1, 16'h0060, 2'd2},
    '{2'd1, 4'd1, 32'hFFFF_F000, 32'h0000_FFFF, 1'b1, 16'h0068, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  level = '0;
  logic [15:0] sel = '0;
  logic [31:0] base = '0, limit = '0;
  logic [3:0]  kind = '0;
  logic        ok = 1'b0;
  logic        mem_req, mem_wide, mem_ready, done, fault, bad;
  logic [31:0] mem_addr, mem_rdata, sp;
  logic [15:0] ss, err;
  int          lat = 0;
  int          wcnt;
  int          checks = 0, fails = 0;
  int          req_n, n_done, n_fault, n_bad;
  logic [31:0] log_addr [64];
  logic        log_wide [64];

  always #5 clk = ~clk;

  priv_stack_fetch dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .level_i(level),
    .tr_sel_i(sel), .tr_base_i(base), .tr_limit_i(limit), .tr_kind_i(kind),
    .tr_ok_i(ok), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_wide_o(mem_wide), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .done_o(done), .ss_o(ss), .sp_o(sp), .fault_o(fault),
    .err_code_o(err), .bad_state_o(bad)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] + a[15:0] + 16'h0101};
  endfunction

  assign mem_ready = mem_req && (wcnt >= lat);
  assign mem_rdata = memf(mem_addr);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= 0; req_n <= 0; n_done <= 0; n_fault <= 0; n_bad <= 0;
    end else begin
      wcnt <= (mem_req && !mem_ready) ? wcnt + 1 : 0;
      if (mem_req && mem_ready) begin
        log_addr[req_n % 64] <= mem_addr;
        log_wide[req_n % 64] <= mem_wide;
        req_n <= req_n + 1;
      end
      if (done)  n_done  <= n_done + 1;
      if (fault) n_fault <= n_fault + 1;
      if (bad)   n_bad   <= n_bad + 1;
    end
  end

  task automatic chk(input logic ok_c, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok_c) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    level = v.lvl; kind = v.kind; base = v.base; limit = v.limit;
    ok = v.ok; sel = v.sel;
  endtask

  task automatic wait_outcome();
    for (int i = 0; i < 60; i++) begin
      if (done || fault || bad) break;
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v, input int l);
    int n0, d0, f0, b0, k;
    logic [31:0] ofs, sp_a, ss_a, exp_sp;
    logic [15:0] exp_ss;
    logic [31:0] hold_sp;
    logic [15:0] hold_ss;
    n0 = req_n; d0 = n_done; f0 = n_fault; b0 = n_bad;
    lat = l;
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_outcome();
    k = done ? 0 : (fault ? 1 : (bad ? 2 : 3));
    chk(k == int'(v.expk), "R10", "outcome kind", 32'(k), 32'(v.expk));
    if (v.kind == 4'd9) begin
      ofs = 32'(v.lvl) * 8 + 4; sp_a = v.base + ofs; ss_a = sp_a + 4;
      exp_sp = memf(sp_a);
    end else begin
      ofs = 32'(v.lvl) * 4 + 2; sp_a = v.base + ofs; ss_a = sp_a + 2;
      exp_sp = {16'h0, memf(sp_a)[15:0]};
    end
    exp_ss = memf(ss_a)[15:0];
    if (v.expk == 2'd1)
      chk(err == (v.sel & 16'hFFFC), "R6", "error code", 32'(err), 32'(v.sel & 16'hFFFC));
    hold_sp = sp; hold_ss = ss;
    repeat (4) @(negedge clk);
    chk((n_done - d0) + (n_fault - f0) + (n_bad - b0) == 1, "R10", "pulse count",
        32'((n_done - d0) + (n_fault - f0) + (n_bad - b0)), 32'd1);
    if (v.expk == 2'd0) begin
      chk(req_n - n0 == 2, v.kind == 4'd9 ? "R2" : "R3", "request count", 32'(req_n - n0), 32'd2);
      chk(log_addr[n0 % 64] == sp_a, v.kind == 4'd9 ? "R2" : "R3", "sp address", log_addr[n0 % 64], sp_a);
      chk(log_wide[n0 % 64] == (v.kind == 4'd9), v.kind == 4'd9 ? "R2" : "R3", "sp width",
          32'(log_wide[n0 % 64]), 32'(v.kind == 4'd9));
      chk(log_addr[(n0 + 1) % 64] == ss_a, "R8", "ss address second", log_addr[(n0 + 1) % 64], ss_a);
      chk(log_wide[(n0 + 1) % 64] == 1'b0, "R8", "ss width", 32'(log_wide[(n0 + 1) % 64]), 32'd0);
      chk(hold_sp == exp_sp, v.kind == 4'd9 ? "R2" : "R3", "sp value", hold_sp, exp_sp);
      chk(hold_ss == exp_ss, "R8", "ss value", 32'(hold_ss), 32'(exp_ss));
      chk(sp == exp_sp && ss == exp_ss, "R8", "values held", sp, exp_sp);
    end else begin
      chk(req_n == n0, v.expk == 2'd1 ? (v.kind == 4'd9 ? "R4" : "R5") : "R7",
          "no memory access", 32'(req_n - n0), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'd0);
    chk(done == 1'b0, "R1", "done in reset", 32'(done), 32'd0);
    chk(fault == 1'b0, "R1", "fault in reset", 32'(fault), 32'd0);
    chk(bad == 1'b0, "R1", "bad_state in reset", 32'(bad), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3);

    // R9: second start while the first fetch is running
    begin
      int n0, d0;
      logic [31:0] a0, exp_sp;
      n0 = req_n; d0 = n_done;
      lat = 3;
      apply(VECS[0]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      apply(VECS[4]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_outcome();
      repeat (8) @(negedge clk);
      a0 = VECS[0].base + 32'd4;
      exp_sp = memf(a0);
      chk(req_n - n0 == 2, "R9", "requests after busy start", 32'(req_n - n0), 32'd2);
      chk(n_done - d0 == 1, "R9", "done pulses", 32'(n_done - d0), 32'd1);
      chk(log_addr[n0 % 64] == a0, "R9", "first request address", log_addr[n0 % 64], a0);
      chk(sp == exp_sp, "R9", "result of first request", sp, exp_sp);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule